// File: doc/BRIEF.md
# Step-phased SD clock generator

This block runs in a fast source clock domain and splits each output clock period into a programmable number of source steps. A single step counter walks through the steps of one period. Three phase comparators watch it and produce three clock enables at independent step offsets:

- a transmit clock at offset zero;
- a card clock, delayed by a register-programmed step count;
- a receive-sample clock, delayed by a step count supplied on an input port.

Interface timing is tuned by sliding the card and sample edges inside the period. Clock muxing cells and the arithmetic that produces the receive delay sit outside the block. The block only reports which source is active.

Software programs the block through a small register interface. It holds the generator in soft reset, chooses a steps-per-cycle code and a source, sets the card delay, and then releases the reset. The generator counts as ready once all three running flags read 1.

Top module: `sdclk_gen`

## Requirements
- R1: The steps-per-cycle code selects the period N. Code 0 gives 20, 1 gives 10, 2 gives 16, 3 gives 8, 4 gives 12, 5 gives 6, 6 gives 5 and 7 gives 4. In steady state the transmit enable is high for floor(N/2) consecutive source cycles out of every N.
- R2: The card enable has the same waveform as the transmit enable, delayed by (card delay mod N) source cycles.
- R3: The sample enable has the same waveform as the transmit enable, delayed by (rx_delay mod N) source cycles.
- R4: The soft-reset bit is bit 0 of address 2 and reads 1 after rst. While it is 1, all three enables stay low and the counter is held. Writing 0 to it starts the generator, and writing 1 to it stops the enables within two cycles.
- R5: Source code 0 means stopped. While the active source is 0, all enables stay low and all running flags read 0. Codes 1, 2 and 3 run the generator.
- R6: Address 2 reports running flags for the transmit clock (bit 8), the card clock (bit 12) and the sample clock (bit 16). Each flag reads 1 once its enable has been high since the generator last started running. Each flag reads 0 whenever the generator is not running.
- R7: New values of the code, the source, the card delay and rx_delay are picked up only when the counter wraps, or at once while soft reset is held or the active source is stopped. Every high pulse therefore lasts a whole half period of one setting, and no runt pulse appears.
- R8: The register map has three writable fields. Address 0 holds the code in bits [2:0] and the source in bits [5:4], with reset value 0. Address 1 holds the card delay in bits [4:0], with reset value 5. Address 2 bit 0 is the soft reset. All other bits, and all of address 3, ignore writes and read 0.
- R9: src_active shows the source code that is currently in effect, so that an external clock mux can follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| rx_delay | input | 5 | Sample clock delay in steps |
| tx_clk_en | output | 1 | Transmit clock enable |
| card_clk_en | output | 1 | Card clock enable |
| rx_clk_en | output | 1 | Sample clock enable |
| src_active | output | 2 | Source code currently in effect |

## Verification
The bench sweeps every steps-per-cycle code against card delays of zero, mid-period, one just past N and the maximum 31, and against several sample delays. This sweep exposes a wrong code table, a missing modulo fold (an enable that never rises or is stuck), and odd-N half periods computed as ceil rather than floor.

It also changes the period and the card delay in the middle of a cycle and measures every high pulse. A design that applied the change at once would emit a short pulse.

Stopping the source, re-asserting soft reset, and writing all ones to every address cover:
- a design that keeps toggling while idle;
- running flags that stay set after a stop;
- reserved bits that latch written data.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int STEP_W = 5;
    localparam int DLY_W  = 5;
    localparam int CODE_W = 3;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 2;
    localparam int NUM_PH = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CFG = 2'd0;
    localparam logic [ADDR_W-1:0] A_DLY = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTL = 2'd2;

    // field positions
    localparam int F_CODE_LSB = 0;
    localparam int F_SRC_LSB  = 4;
    localparam int ST_TX      = 8;
    localparam int ST_CARD    = 12;
    localparam int ST_RX      = 16;

    typedef enum logic [1:0] {
        SRC_STOP  = 2'd0,
        SRC_ALT   = 2'd1,
        SRC_PLL   = 2'd2,
        SRC_PLL_B = 2'd3
    } src_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        src_t              src;
        logic [DLY_W-1:0]  card_dly;
        logic [DLY_W-1:0]  rx_dly;
    } gen_cfg_t;

    // steps in one output period for a given code
    function automatic logic [STEP_W-1:0] steps_of(input logic [CODE_W-1:0] c);
        logic [STEP_W-1:0] n;
        case (c)
            3'd0:    n = 5'd20;
            3'd1:    n = 5'd10;
            3'd2:    n = 5'd16;
            3'd3:    n = 5'd8;
            3'd4:    n = 5'd12;
            3'd5:    n = 5'd6;
            3'd6:    n = 5'd5;
            default: n = 5'd4;
        endcase
        return n;
    endfunction

    // fold a delay into the current period
    function automatic logic [STEP_W-1:0] fold_off(input logic [DLY_W-1:0] off,
                                                   input logic [STEP_W-1:0] n);
        logic [STEP_W-1:0] r;
        if (n == '0) r = '0;
        else         r = off % n;
        return r;
    endfunction

endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
    import sdclk_pkg::*;
#(
    parameter int unsigned DEF_CARD_DLY = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NUM_PH-1:0] status,
    output logic [CODE_W-1:0] pend_code,
    output src_t              pend_src,
    output logic [DLY_W-1:0]  pend_card,
    output logic              srst
);

    logic [CODE_W-1:0] code_q;
    src_t              src_q;
    logic [DLY_W-1:0]  card_q;
    logic              srst_q;
    logic              unused_wr;

    assign unused_wr = ^{wr_data[REG_W-1:F_SRC_LSB+2], wr_data[F_SRC_LSB-1:CODE_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            src_q  <= SRC_STOP;
            card_q <= DLY_W'(DEF_CARD_DLY);
            srst_q <= 1'b1;
        end else if (wr_en) begin
            case (wr_addr)
                A_CFG: begin
                    code_q <= wr_data[F_CODE_LSB +: CODE_W];
                    src_q  <= src_t'(wr_data[F_SRC_LSB +: 2]);
                end
                A_DLY:   card_q <= wr_data[DLY_W-1:0];
                A_CTL:   srst_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CFG: begin
                rd_data[F_CODE_LSB +: CODE_W] = code_q;
                rd_data[F_SRC_LSB +: 2]       = src_q;
            end
            A_DLY: rd_data[DLY_W-1:0] = card_q;
            A_CTL: begin
                rd_data[0]       = srst_q;
                rd_data[ST_TX]   = status[0];
                rd_data[ST_CARD] = status[1];
                rd_data[ST_RX]   = status[2];
            end
            default: rd_data = '0;
        endcase
    end

    assign pend_code = code_q;
    assign pend_src  = src_q;
    assign pend_card = card_q;
    assign srst      = srst_q;

    // R4: a control write lands in the soft-reset bit
    a_r4_ctl_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_CTL) |=> (srst_q == $past(wr_data[0])));

    // R8: the card delay changes only through its own address
    a_r8_dly_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == A_DLY) |=> $stable(card_q));

endmodule

// File: rtl/sdclk_stepper.sv
module sdclk_stepper
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  gen_cfg_t          pend,
    output gen_cfg_t          act,
    output logic [STEP_W-1:0] cnt,
    output logic [STEP_W-1:0] n,
    output logic [STEP_W-1:0] half,
    output logic              run
);

    gen_cfg_t          act_q;
    logic [STEP_W-1:0] cnt_q;
    logic              load;

    assign n    = steps_of(act_q.code);
    assign half = n >> 1;
    assign run  = !srst && (act_q.src != SRC_STOP);

    // new settings are taken only at a period boundary or while idle
    assign load = srst || (act_q.src == SRC_STOP) || (cnt_q == n - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            act_q <= pend;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign act = act_q;
    assign cnt = cnt_q;

    // R1: counter stays inside the active period
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < n);

    // R7: the active setting only moves when a fresh period begins
    a_r7_cfg_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> (cnt_q == '0));

    // R5: a stopped source keeps the counter parked
    a_r5_stop_parks: assert property (@(posedge clk) disable iff (rst)
        (act_q.src == SRC_STOP) |=> (cnt_q == '0));

endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [STEP_W-1:0] cnt,
    input  logic [STEP_W-1:0] n,
    input  logic [STEP_W-1:0] half,
    input  logic [DLY_W-1:0]  off,
    output logic              en,
    output logic              seen
);

    logic [STEP_W-1:0] offm;
    logic              at_edge;
    logic              en_q;
    logic              seen_q;
    logic [STEP_W-1:0] rem_q;

    assign offm    = fold_off(off, n);
    assign at_edge = (cnt == offm);

    // rise at the own offset, then hold high for a latched half period
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            en_q  <= 1'b0;
            rem_q <= '0;
        end else if (at_edge) begin
            en_q  <= 1'b1;
            rem_q <= half - 1'b1;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end else begin
            en_q  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= run && (seen_q || en_q);
    end

    assign en   = en_q;
    assign seen = seen_q;

    // R4: idle generator drives no enable
    a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
        !run |=> !en_q);

    // R6: running flag only after the enable was high
    a_r6_seen_after_high: assert property (@(posedge clk) disable iff (rst)
        $rose(seen_q) |-> $past(en_q));

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int unsigned DEF_CARD_DLY = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic [4:0]  rx_delay,
    output logic        tx_clk_en,
    output logic        card_clk_en,
    output logic        rx_clk_en,
    output logic [1:0]  src_active
);

    logic [CODE_W-1:0] pend_code;
    src_t              pend_src;
    logic [DLY_W-1:0]  pend_card;
    logic              srst;
    gen_cfg_t          pend;
    gen_cfg_t          act;
    logic [STEP_W-1:0] cnt;
    logic [STEP_W-1:0] n;
    logic [STEP_W-1:0] half;
    logic              run;
    logic [DLY_W-1:0]  ph_off [NUM_PH];
    logic [NUM_PH-1:0] ph_en;
    logic [NUM_PH-1:0] ph_seen;

    sdclk_regs #(.DEF_CARD_DLY(DEF_CARD_DLY)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .status    (ph_seen),
        .pend_code (pend_code),
        .pend_src  (pend_src),
        .pend_card (pend_card),
        .srst      (srst)
    );

    always_comb begin
        pend.code     = pend_code;
        pend.src      = pend_src;
        pend.card_dly = pend_card;
        pend.rx_dly   = rx_delay;
    end

    sdclk_stepper u_step (
        .clk  (clk),
        .rst  (rst),
        .srst (srst),
        .pend (pend),
        .act  (act),
        .cnt  (cnt),
        .n    (n),
        .half (half),
        .run  (run)
    );

    assign ph_off[0] = '0;
    assign ph_off[1] = act.card_dly;
    assign ph_off[2] = act.rx_dly;

    for (genvar k = 0; k < NUM_PH; k++) begin : g_ph
        sdclk_phase u_ph (
            .clk  (clk),
            .rst  (rst),
            .run  (run),
            .cnt  (cnt),
            .n    (n),
            .half (half),
            .off  (ph_off[k]),
            .en   (ph_en[k]),
            .seen (ph_seen[k])
        );
    end

    assign tx_clk_en   = ph_en[0];
    assign card_clk_en = ph_en[1];
    assign rx_clk_en   = ph_en[2];
    assign src_active  = act.src;

    // R5: a source that has been stopped for two edges leaves all enables low
    a_r5_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        (src_active == 2'd0 && $past(src_active) == 2'd0) |-> (ph_en == '0));

endmodule

// File: tb/tb_sdclk_gen.sv
module tb_sdclk_gen;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] AD_CFG = 2'd0;
    localparam logic [1:0] AD_DLY = 2'd1;
    localparam logic [1:0] AD_CTL = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [4:0]  rx_delay = '0;
    logic        tx_clk_en, card_clk_en, rx_clk_en;
    logic [1:0]  src_active;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [31:0] v;

    sdclk_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_delay(rx_delay),
        .tx_clk_en(tx_clk_en), .card_clk_en(card_clk_en), .rx_clk_en(rx_clk_en),
        .src_active(src_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint actual, input longint expected);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic int steps_exp(input int c);
        case (c)
            0: return 20;  1: return 10;  2: return 16;  3: return 8;
            4: return 12;  5: return 6;   6: return 5;   default: return 4;
        endcase
    endfunction

    function automatic bit hi_exp(input int k, input int d, input int n);
        int r;
        r = (((k - d) % n) + n) % n;
        return r < (n / 2);
    endfunction

    task automatic wait_tx_rise();
        int w;
        w = 0;
        while (tx_clk_en && w < 100) begin @(negedge clk); w++; end
        while (!tx_clk_en && w < 200) begin @(negedge clk); w++; end
        check(tx_clk_en == 1'b1, "R1", "transmit enable rises", tx_clk_en, 1);
    endtask

    // compare 2N cycles of all three enables against the arithmetic model
    task automatic cmp_window(input int n, input int cd, input int rx, input string tag);
        int e_tx, e_cd, e_rx;
        e_tx = 0; e_cd = 0; e_rx = 0;
        wait_tx_rise();
        repeat (n) @(negedge clk);
        for (int k = 0; k < 2 * n; k++) begin
            if (tx_clk_en   !== hi_exp(k, 0, n))  e_tx++;
            if (card_clk_en !== hi_exp(k, cd, n)) e_cd++;
            if (rx_clk_en   !== hi_exp(k, rx, n)) e_rx++;
            @(negedge clk);
        end
        check(e_tx == 0, "R1", {tag, " transmit waveform mismatches"}, e_tx, 0);
        check(e_cd == 0, "R2", {tag, " card waveform mismatches"}, e_cd, 0);
        check(e_rx == 0, "R3", {tag, " sample waveform mismatches"}, e_rx, 0);
    endtask

    task automatic run_cfg(input int c, input int src, input int cd, input int rx);
        int n;
        n = steps_exp(c);
        wr(AD_CTL, 32'd1);
        wr(AD_CFG, 32'(c) | (32'(src) << 4));
        wr(AD_DLY, 32'(cd));
        rx_delay = 5'(rx);
        wr(AD_CTL, 32'd0);
        cmp_window(n, cd, rx, "sweep");
        rd(AD_CTL, v);
        check(v == 32'h0001_1100, "R6", "all three running flags set", v, 32'h0001_1100);
        check(src_active == 2'(src), "R9", "active source", src_active, src);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < cycles; i++) begin
            if (tx_clk_en || card_clk_en || rx_clk_en) bad++;
            @(negedge clk);
        end
        check(bad == 0, req, "cycles with an enable high while idle", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int cds[4];
        int rxs[3];
        int bad_tx, bad_cd, np_tx, np_cd, len_tx, len_cd;
        bit arm_tx, arm_cd;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(AD_CTL, v); check(v == 32'd1, "R4", "soft reset bit after rst", v, 1);
        rd(AD_DLY, v); check(v == 32'd5, "R8", "card delay reset value", v, 5);
        rd(AD_CFG, v); check(v == 32'd0, "R8", "config reset value", v, 0);
        expect_quiet(10, "R4");

        // released but source stopped
        wr(AD_CTL, 32'd0);
        expect_quiet(20, "R5");
        rd(AD_CTL, v); check(v == 32'd0, "R5", "flags with stopped source", v, 0);

        // sweep every code against several delays
        for (int c = 0; c < 8; c++) begin
            cds[0] = 0; cds[1] = 5; cds[2] = steps_exp(c) + 3; cds[3] = 31;
            rxs[0] = 6; rxs[1] = 0; rxs[2] = 19;
            foreach (cds[i]) begin
                foreach (rxs[j]) begin
                    run_cfg(c, 1 + (c % 3), cds[i], rxs[j]);
                end
            end
        end

        // R7: change period and card delay in the middle of a cycle
        run_cfg(0, 1, 5, 6);
        wait_tx_rise();
        @(negedge clk);
        wr(AD_CFG, 32'h13);
        wr(AD_DLY, 32'd2);
        bad_tx = 0; bad_cd = 0; np_tx = 0; np_cd = 0; len_tx = 0; len_cd = 0;
        arm_tx = 1'b0; arm_cd = 1'b0;
        for (int i = 0; i < 120; i++) begin
            if (tx_clk_en) len_tx++;
            else begin
                if (arm_tx && len_tx > 0) begin
                    np_tx++;
                    if (len_tx != 10 && len_tx != 4) bad_tx++;
                end
                arm_tx = 1'b1; len_tx = 0;
            end
            if (card_clk_en) len_cd++;
            else begin
                if (arm_cd && len_cd > 0) begin
                    np_cd++;
                    if (len_cd != 10 && len_cd != 4) bad_cd++;
                end
                arm_cd = 1'b1; len_cd = 0;
            end
            @(negedge clk);
        end
        check(bad_tx == 0, "R7", "transmit runt pulses", bad_tx, 0);
        check(bad_cd == 0, "R7", "card runt pulses", bad_cd, 0);
        check(np_tx >= 5, "R7", "transmit pulses seen", np_tx, 5);
        check(np_cd >= 5, "R7", "card pulses seen", np_cd, 5);
        cmp_window(8, 2, 6, "R7 after change");

        // R4: soft reset while running
        wr(AD_CTL, 32'd1);
        @(negedge clk);
        expect_quiet(15, "R4");
        rd(AD_CTL, v); check(v == 32'd1, "R4", "control read in soft reset", v, 1);

        // R5: stop the source while running
        run_cfg(4, 2, 3, 7);
        wr(AD_CFG, 32'h04);
        repeat (15) @(negedge clk);
        expect_quiet(20, "R5");
        rd(AD_CTL, v); check(v == 32'd0, "R5", "flags after stop", v, 0);
        check(src_active == 2'd0, "R9", "active source after stop", src_active, 0);

        // R8: reserved bits ignore writes
        wr(AD_CTL, 32'hFFFF_FFFF);
        rd(AD_CTL, v); check(v == 32'd1, "R8", "control readback of all ones", v, 1);
        wr(AD_CFG, 32'hFFFF_FFFF);
        rd(AD_CFG, v); check(v == 32'h37, "R8", "config readback of all ones", v, 32'h37);
        wr(AD_DLY, 32'hFFFF_FFE9);
        rd(AD_DLY, v); check(v == 32'd9, "R8", "delay readback", v, 9);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check(v == 32'd0, "R8", "unused address readback", v, 0);
        expect_quiet(10, "R4");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule